// File: doc/BRIEF.md
# UART Interrupt Status Controller

This block produces the interrupt view of a UART. It takes the occupancy counts of the receive and transmit FIFOs and compares them with two programmable trigger levels. From these it forms a live status word that is recomputed every cycle. Each live condition, and each one-cycle event pulse from the serial engine (overrun, framing, parity, receive timeout, modem status change, transmit overflow), is latched into a sticky interrupt register. Software clears that register by writing ones.

An interrupt mask selects which sticky bits reach the single level-sensitive interrupt line. Software never loads the mask as a whole. One register address sets mask bits and another clears them. A direct write to the mask address has no effect. A small synchronous write port and a combinational read port give software access to all of this.

The transmit-trigger condition sits at bit 13 of the live word but lands at bit 10 of the sticky register. The latching path therefore remaps it and does not copy it straight across.

Top module: `uart_irq_status_ctrl`

## Requirements
- R1: The live status word (`status_o`, and read data at address 6) is combinational from the counts and trigger levels. Bit 0 = rx count >= rx trigger. Bit 1 = rx count == 0. Bit 2 = rx count == FIFO_DEPTH. Bit 3 = tx count == 0. Bit 4 = tx count == FIFO_DEPTH. Bit 13 = tx count >= tx trigger. All other bits are 0.
- R2: Whenever live bit k (k = 0..4) is high at a rising clock edge, sticky bit k is set after that edge and not before it.
- R3: Live bit 13 sets sticky bit 10 one clock later. The sticky register has no bit 13, and its read data bit 13 is always 0.
- R4: A one-cycle event pulse sets its sticky bit at the next edge: rx overrun bit 5, framing bit 6, parity bit 7, receive timeout bit 8, modem status bit 9, tx overflow bit 12.
- R5: Writing address 3 (sticky register) clears exactly the sticky bits written as one. All other bits keep their value. Address 3 reads back the sticky register.
- R6: When a set condition (live bit or event) and a clear hit the same sticky bit in the same cycle, the bit stays set.
- R7: Writing address 0 ORs the written bits into the mask. Writing address 1 clears the written bits from the mask. Writing address 2 leaves the mask unchanged. Address 2 reads back the mask.
- R8: `irq_o` is high exactly when (mask AND sticky) is non-zero. It follows the registers with no added cycle.
- R9: Asynchronous reset clears the mask and the sticky register and sets both trigger levels to 32.
- R10: Writing address 4 or 5 loads the rx or tx trigger level from the low bits of the data, and the level reads back at the same address. A new level affects the live trigger flags immediately. A level of 0 keeps its flag set at every count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_cnt_i | input | CNT_W | Receive FIFO occupancy |
| tx_cnt_i | input | CNT_W | Transmit FIFO occupancy |
| ev_rx_ovr_i | input | 1 | Receive overrun pulse |
| ev_frame_i | input | 1 | Framing error pulse |
| ev_parity_i | input | 1 | Parity error pulse |
| ev_timeout_i | input | 1 | Receive timeout pulse |
| ev_modem_i | input | 1 | Modem status change pulse |
| ev_tx_ovf_i | input | 1 | Transmit overflow pulse |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address for read and write |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for `addr_i` |
| status_o | output | DATA_W | Live status word |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions assume two things about the counts. First, the FIFO counts never exceed FIFO_DEPTH, so the empty and full flags cannot both be high. Second, only one register address is written per cycle. The stimulus keeps the counts within 0..FIFO_DEPTH and issues writes one at a time through a single task. It also holds the counts at a neutral pair (both 5, below the default trigger levels) whenever a test needs the live word to be quiet. With the counts quiet, the sticky bits a test sets come only from its own stimulus.

// File: rtl/uist_pkg.sv
package uist_pkg;
  localparam int LIVE_W = 14;
  localparam int ST_W   = 13;

  localparam int LV_RX_TRIG  = 0;
  localparam int LV_RX_EMPTY = 1;
  localparam int LV_RX_FULL  = 2;
  localparam int LV_TX_EMPTY = 3;
  localparam int LV_TX_FULL  = 4;
  localparam int LV_TX_TRIG  = 13;
  localparam int LV_COPY_W   = 5;

  localparam int ST_RX_OVR  = 5;
  localparam int ST_FRAME   = 6;
  localparam int ST_PARITY  = 7;
  localparam int ST_TIMEOUT = 8;
  localparam int ST_MODEM   = 9;
  localparam int ST_TX_TRIG = 10;
  localparam int ST_TX_OVF  = 12;

  typedef enum logic [2:0] {
    A_MASK_SET = 3'd0,
    A_MASK_CLR = 3'd1,
    A_MASK     = 3'd2,
    A_STICKY   = 3'd3,
    A_RX_TRIG  = 3'd4,
    A_TX_TRIG  = 3'd5,
    A_LIVE     = 3'd6
  } reg_addr_e;

  typedef struct packed {
    logic tx_ovf;
    logic modem;
    logic timeout;
    logic parity;
    logic frame;
    logic rx_ovr;
  } evt_t;
endpackage

// File: rtl/uist_live_status.sv
module uist_live_status
  import uist_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = 7
) (
  input  logic [1:0][CNT_W-1:0] cnt_i,   // [0]=rx, [1]=tx
  input  logic [1:0][CNT_W-1:0] trig_i,
  output logic [LIVE_W-1:0]     live_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [1:0] at_trig, is_empty, is_full;

  for (genvar d = 0; d < 2; d++) begin : g_dir
    assign at_trig[d]  = cnt_i[d] >= trig_i[d];
    assign is_empty[d] = cnt_i[d] == '0;
    assign is_full[d]  = cnt_i[d] == FULL_CNT;
  end

  always_comb begin
    live_o              = '0;
    live_o[LV_RX_TRIG]  = at_trig[0];
    live_o[LV_RX_EMPTY] = is_empty[0];
    live_o[LV_RX_FULL]  = is_full[0];
    live_o[LV_TX_EMPTY] = is_empty[1];
    live_o[LV_TX_FULL]  = is_full[1];
    live_o[LV_TX_TRIG]  = at_trig[1];
  end
endmodule

// File: rtl/uist_trig_regs.sv
module uist_trig_regs #(
  parameter int CNT_W    = 7,
  parameter int TRIG_RST = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [1:0]            wr_i,
  input  logic [CNT_W-1:0]      wdata_i,
  output logic [1:0][CNT_W-1:0] trig_o
);
  for (genvar d = 0; d < 2; d++) begin : g_trig
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      trig_o[d] <= CNT_W'(TRIG_RST);
      else if (wr_i[d]) trig_o[d] <= wdata_i;
    end
  end

  AST_TRIG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i == 2'b00) |=> $stable(trig_o)); // R10
endmodule

// File: rtl/uist_sticky.sv
module uist_sticky
  import uist_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LIVE_W-1:0] live_i,
  input  evt_t              evt_i,
  input  logic              clr_en_i,
  input  logic [ST_W-1:0]   clr_bits_i,
  output logic [ST_W-1:0]   sticky_o
);
  logic [ST_W-1:0] set_vec, clr_vec;
  logic            unused_live;

  assign unused_live = ^live_i[LV_TX_TRIG-1:LV_COPY_W];

  always_comb begin
    set_vec                  = '0;
    set_vec[LV_COPY_W-1:0]   = live_i[LV_COPY_W-1:0];
    set_vec[ST_TX_TRIG]      = live_i[LV_TX_TRIG];  // remapped position
    set_vec[ST_RX_OVR]       = evt_i.rx_ovr;
    set_vec[ST_FRAME]        = evt_i.frame;
    set_vec[ST_PARITY]       = evt_i.parity;
    set_vec[ST_TIMEOUT]      = evt_i.timeout;
    set_vec[ST_MODEM]        = evt_i.modem;
    set_vec[ST_TX_OVF]       = evt_i.tx_ovf;
    clr_vec                  = clr_en_i ? clr_bits_i : '0;
  end

  // set after clear: a same-cycle set wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sticky_o <= '0;
    else         sticky_o <= (sticky_o & ~clr_vec) | set_vec;
  end

  for (genvar k = 0; k < LV_COPY_W; k++) begin : g_chk
    AST_LIVE_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      live_i[k] |=> sticky_o[k]); // R2
  end

  AST_TX_TRIG_REMAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_i[LV_TX_TRIG] |=> sticky_o[ST_TX_TRIG]); // R3
  AST_OVR_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i.rx_ovr |=> sticky_o[ST_RX_OVR]); // R4
  AST_TXOVF_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i.tx_ovf |=> sticky_o[ST_TX_OVF]); // R4
  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_en_i && clr_bits_i[ST_FRAME] && !evt_i.frame) |=> !sticky_o[ST_FRAME]); // R5
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_en_i && clr_bits_i[ST_RX_OVR] && evt_i.rx_ovr) |=> sticky_o[ST_RX_OVR]); // R6
endmodule

// File: rtl/uist_mask.sv
module uist_mask
  import uist_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            set_en_i,
  input  logic            clr_en_i,
  input  logic [ST_W-1:0] bits_i,
  input  logic [ST_W-1:0] sticky_i,
  output logic [ST_W-1:0] mask_o,
  output logic            irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       mask_o <= '0;
    else if (set_en_i) mask_o <= mask_o | bits_i;
    else if (clr_en_i) mask_o <= mask_o & ~bits_i;
  end

  assign irq_o = |(mask_o & sticky_i);

  AST_MASK_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_en_i |=> ((mask_o & $past(bits_i)) == $past(bits_i))); // R7
  AST_MASK_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_en_i && !set_en_i) |=> ((mask_o & $past(bits_i)) == '0)); // R7
  AST_MASK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_en_i && !clr_en_i) |=> $stable(mask_o)); // R7
endmodule

// File: rtl/uart_irq_status_ctrl.sv
module uart_irq_status_ctrl
  import uist_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int TRIG_RST   = 32,
  parameter int DATA_W     = 16,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  rx_cnt_i,
  input  logic [CNT_W-1:0]  tx_cnt_i,
  input  logic              ev_rx_ovr_i,
  input  logic              ev_frame_i,
  input  logic              ev_parity_i,
  input  logic              ev_timeout_i,
  input  logic              ev_modem_i,
  input  logic              ev_tx_ovf_i,
  input  logic              wr_en_i,
  input  logic [2:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] status_o,
  output logic              irq_o
);
  logic [1:0][CNT_W-1:0] cnt, trig;
  logic [LIVE_W-1:0]     live;
  logic [ST_W-1:0]       sticky, mask;
  evt_t                  evt;
  logic                  wr_set, wr_clr, wr_w1c;
  logic [1:0]            wr_trig;
  logic                  unused_wdata;

  assign cnt      = {tx_cnt_i, rx_cnt_i};
  assign evt      = '{tx_ovf: ev_tx_ovf_i, modem: ev_modem_i, timeout: ev_timeout_i,
                      parity: ev_parity_i, frame: ev_frame_i, rx_ovr: ev_rx_ovr_i};
  assign wr_set   = wr_en_i && (addr_i == A_MASK_SET);
  assign wr_clr   = wr_en_i && (addr_i == A_MASK_CLR);
  assign wr_w1c   = wr_en_i && (addr_i == A_STICKY);
  assign wr_trig  = {wr_en_i && (addr_i == A_TX_TRIG), wr_en_i && (addr_i == A_RX_TRIG)};
  assign unused_wdata = ^wdata_i[DATA_W-1:ST_W];

  uist_trig_regs #(.CNT_W(CNT_W), .TRIG_RST(TRIG_RST)) u_trig (
    .clk_i, .rst_ni, .wr_i(wr_trig), .wdata_i(wdata_i[CNT_W-1:0]), .trig_o(trig)
  );

  uist_live_status #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_live (
    .cnt_i(cnt), .trig_i(trig), .live_o(live)
  );

  uist_sticky u_sticky (
    .clk_i, .rst_ni, .live_i(live), .evt_i(evt),
    .clr_en_i(wr_w1c), .clr_bits_i(wdata_i[ST_W-1:0]), .sticky_o(sticky)
  );

  uist_mask u_mask (
    .clk_i, .rst_ni, .set_en_i(wr_set), .clr_en_i(wr_clr),
    .bits_i(wdata_i[ST_W-1:0]), .sticky_i(sticky), .mask_o(mask), .irq_o
  );

  assign status_o = DATA_W'(live);

  always_comb begin
    case (addr_i)
      A_MASK:    rdata_o = DATA_W'(mask);
      A_STICKY:  rdata_o = DATA_W'(sticky);
      A_RX_TRIG: rdata_o = DATA_W'(trig[0]);
      A_TX_TRIG: rdata_o = DATA_W'(trig[1]);
      A_LIVE:    rdata_o = DATA_W'(live);
      default:   rdata_o = '0;
    endcase
  end

  AST_EMPTY_FULL_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(status_o[LV_RX_EMPTY] && status_o[LV_RX_FULL])); // R1
  AST_MASK_NO_DIRECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_MASK) |=> $stable(mask)); // R7
  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sticky == '0) |-> !irq_o); // R8
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask == '0) |-> !irq_o); // R8
endmodule

// File: tb/uart_irq_status_ctrl_tb.sv
module uart_irq_status_ctrl_tb;
  localparam int DEPTH = 64;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int DW    = 16;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [CNT_W-1:0] rx_cnt = 7'd5, tx_cnt = 7'd5;
  logic ev_rx_ovr = 0, ev_frame = 0, ev_parity = 0, ev_timeout = 0, ev_modem = 0, ev_tx_ovf = 0;
  logic wr_en = 0;
  logic [2:0] addr = 3'd0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata, status;
  logic irq;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  uart_irq_status_ctrl #(.FIFO_DEPTH(DEPTH)) u_dut (
    .clk_i(clk), .rst_ni, .rx_cnt_i(rx_cnt), .tx_cnt_i(tx_cnt),
    .ev_rx_ovr_i(ev_rx_ovr), .ev_frame_i(ev_frame), .ev_parity_i(ev_parity),
    .ev_timeout_i(ev_timeout), .ev_modem_i(ev_modem), .ev_tx_ovf_i(ev_tx_ovf),
    .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .status_o(status), .irq_o(irq)
  );

  function automatic logic [DW-1:0] exp_live(int rx, int tx, int rt, int tt);
    logic [DW-1:0] v = '0;
    v[0]  = rx >= rt;
    v[1]  = rx == 0;
    v[2]  = rx == DEPTH;
    v[3]  = tx == 0;
    v[4]  = tx == DEPTH;
    v[13] = tx >= tt;
    return v;
  endfunction

  function automatic logic [DW-1:0] exp_map(logic [DW-1:0] lv);
    logic [DW-1:0] v = '0;
    v[4:0] = lv[4:0];
    v[10]  = lv[13];
    return v;
  endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [DW-1:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic quiet_clear();
    logic [DW-1:0] d;
    @(negedge clk);
    rx_cnt = 5; tx_cnt = 5;
    wr(3'd3, 16'h1FFF);
    rd(3'd3, d);
    chk("R5 clear all", d, '0);
  endtask

  task automatic pulse(int which);
    @(negedge clk);
    case (which)
      0: ev_rx_ovr = 1; 1: ev_frame = 1; 2: ev_parity = 1;
      3: ev_timeout = 1; 4: ev_modem = 1; default: ev_tx_ovf = 1;
    endcase
    @(negedge clk);
    {ev_rx_ovr, ev_frame, ev_parity, ev_timeout, ev_modem, ev_tx_ovf} = '0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    int trigs[4] = '{0, 1, 32, 64};
    int rxs[6] = '{40, 0, 64, 5, 5, 5};
    int txs[6] = '{5, 5, 5, 0, 64, 40};
    int evbit[6] = '{5, 6, 7, 8, 9, 12};

    // R9 reset state
    #3;
    rd(3'd2, d); chk("R9 mask reset", d, '0);
    rd(3'd3, d); chk("R9 sticky reset", d, '0);
    rd(3'd4, d); chk("R9 rx trig reset", d, 16'd32);
    rd(3'd5, d); chk("R9 tx trig reset", d, 16'd32);
    @(negedge clk); rst_ni = 1;
    @(negedge clk);
    rd(3'd3, d); chk("R9 sticky quiet after reset", d, '0);

    // R1 / R10 sweep over counts and trigger levels
    foreach (trigs[i]) begin
      wr(3'd4, 16'(trigs[i]));
      wr(3'd5, 16'(trigs[i]));
      rd(3'd4, d); chk("R10 rx trig readback", d, 16'(trigs[i]));
      rd(3'd5, d); chk("R10 tx trig readback", d, 16'(trigs[i]));
      for (int c = 0; c <= DEPTH; c++) begin
        @(negedge clk);
        rx_cnt = CNT_W'(c); tx_cnt = CNT_W'(DEPTH - c);
        #1;
        chk("R1 live word", status, exp_live(c, DEPTH - c, trigs[i], trigs[i]));
      end
      rd(3'd6, d); chk("R1 live via read", d, exp_live(DEPTH, 0, trigs[i], trigs[i]));
    end
    wr(3'd4, 16'd32);
    wr(3'd5, 16'd32);
    quiet_clear();

    // R2 / R3 latching of live conditions, one clock later
    foreach (rxs[i]) begin
      @(negedge clk);
      rx_cnt = CNT_W'(rxs[i]); tx_cnt = CNT_W'(txs[i]);
      rd(3'd3, d); chk("R2 not before edge", d, '0);
      @(negedge clk);
      rd(3'd3, d);
      chk(i == 5 ? "R3 tx trig to bit 10" : "R2 latched after edge", d,
          exp_map(exp_live(rxs[i], txs[i], 32, 32)));
      quiet_clear();
    end

    // R4 event pulses
    for (int e = 0; e < 6; e++) begin
      pulse(e);
      rd(3'd3, d); chk("R4 event bit", d, 16'(1) << evbit[e]);
      quiet_clear();
    end

    // R5 selective clear
    for (int e = 0; e < 6; e++) pulse(e);
    rd(3'd3, d); chk("R4 all events", d, 16'h13E0);
    wr(3'd3, 16'h0520);
    rd(3'd3, d); chk("R5 partial clear", d, 16'h12C0);
    quiet_clear();

    // R6 set wins over clear
    @(negedge clk); rx_cnt = 0;
    @(negedge clk);
    wr(3'd3, 16'h0002);
    rd(3'd3, d); chk("R6 live bit survives clear", d, 16'h0002);
    quiet_clear();
    pulse(0);
    @(negedge clk);
    wr_en = 1; addr = 3'd3; wdata = 16'h0020; ev_rx_ovr = 1;
    @(negedge clk);
    wr_en = 0; ev_rx_ovr = 0;
    rd(3'd3, d); chk("R6 event survives clear", d, 16'h0020);
    quiet_clear();

    // R7 mask set / clear / direct write ignored
    wr(3'd0, 16'h0005); rd(3'd2, d); chk("R7 set", d, 16'h0005);
    wr(3'd0, 16'h0020); rd(3'd2, d); chk("R7 set accumulates", d, 16'h0025);
    wr(3'd1, 16'h0004); rd(3'd2, d); chk("R7 clear", d, 16'h0021);
    wr(3'd2, 16'h1FFF); rd(3'd2, d); chk("R7 direct write ignored", d, 16'h0021);

    // R8 interrupt level
    #1; chk("R8 irq low no sticky", 16'(irq), 16'd0);
    pulse(1);
    #1; chk("R8 unmasked bit no irq", 16'(irq), 16'd0);
    pulse(0);
    #1; chk("R8 irq high", 16'(irq), 16'd1);
    wr(3'd1, 16'h0020);
    #1; chk("R8 irq drops on mask clear", 16'(irq), 16'd0);
    wr(3'd0, 16'h0020);
    #1; chk("R8 irq back on mask set", 16'(irq), 16'd1);
    wr(3'd3, 16'h0020);
    #1; chk("R8 irq drops on sticky clear", 16'(irq), 16'd0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule